// File: doc/BRIEF.md
# DMA Page Translation Engine

This block turns the virtual addresses issued by a DMA master into 36-bit physical addresses. It walks a single-level table of 32-bit page entries held in system memory. For each 4 KB page of a transfer it forms the entry address from a table base value and a window start value. It reads that one word over a simple memory request/response port, checks the entry's permission flags, and then either hands back the physical address of the piece or records a fault.

A transfer is given as a start address, a byte count and a direction. The engine splits it at 4 KB boundaries and translates each page on its own, with a fresh table read for every page. It reports every piece with its physical address, its byte count and a flag on the final piece. A permission failure stops the rest of the transfer. It loads a fault status word and the page-aligned faulting address, and raises an interrupt that stays high until it is cleared. There is no translation cache, so every page costs one memory round trip.

Top module: `dma_xlate`

## Requirements
- R1: A request is taken only while `req_ready` is 1, which holds only when the engine is idle. A request presented while busy is ignored. A request with `req_len` of 0 causes no table read and no output.
- R2: Each page translated costs exactly one table read. `mem_addr` equals `{cfg_base,4'h0} + (((vaddr & ~cfg_win) >> 10) & ~3)`, taken as a 36-bit sum, where vaddr is the current page's address.
- R3: A piece's physical address is `{entry[31:8], vaddr[11:0]}`. Entry bit 7 (cacheable) and bit 0 (write-as-zero) do not change the outcome.
- R4: An entry whose bit 1 (valid) is 0 faults on a read or a write.
- R5: An entry whose bit 2 (writable) is 0 faults on a write and translates normally on a read.
- R6: On a fault, `fault_status` becomes 0xC0820000 for a write or 0xC0860000 for a read. `fault_addr` becomes the faulting page address with its low 12 bits zero.
- R7: `irq` rises together with the fault pulse and stays at 1 until a cycle with `irq_clr` at 1. A fault in the same cycle as the clear leaves it at 1.
- R8: A transfer is cut at 4 KB boundaries. Each piece reports min(bytes left, 4096 − page offset) in `out_bytes`, and `out_last` is 1 only on the final piece.
- R9: After a fault, no further table read and no further piece is issued for that transfer.
- R10: After reset, `req_ready` is 1, `irq`, `out_valid` and `xl_fault` are 0, `fault_status` is 0x00800000 and `fault_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_vaddr | input | 32 | Start virtual address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| cfg_base | input | 32 | Table base value (shifted left by 4) |
| cfg_win | input | 32 | Window start value |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 36 | Table entry address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table entry word |
| out_valid | output | 1 | One-cycle pulse: a piece is translated |
| out_paddr | output | 36 | Physical address of the piece |
| out_bytes | output | LEN_W | Byte count of the piece |
| out_last | output | 1 | Piece is the final one of the transfer |
| xl_fault | output | 1 | One-cycle pulse: translation fault |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Page-aligned faulting virtual address |
| irq | output | 1 | Fault interrupt, held until cleared |
| irq_clr | input | 1 | Clears the interrupt |

## Verification
The hardest case to reach is a fault on a later page of a transfer that spans several pages. In that case the earlier pieces must come out intact, and then both the table reads and the output must stop. The bench computes the entry address of one chosen later page and makes only that entry invalid. Random table contents then mix valid, read-only and invalid entries across transfers that start near page ends. A randomly chosen response latency moves the check step against the request flow, and a request presented while the engine is busy confirms that it is ignored.

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  input  logic [31:0]      cfg_base,
  input  logic [31:0]      cfg_win,
  output logic             mem_req,
  output logic [35:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             out_valid,
  output logic [35:0]      out_paddr,
  output logic [LEN_W-1:0] out_bytes,
  output logic             out_last,
  output logic             xl_fault,
  output logic [31:0]      fault_status,
  output logic [31:0]      fault_addr,
  output logic             irq,
  input  logic             irq_clr
);
  localparam int PG_SH = 12;
  localparam logic [PG_SH:0] PG_BYTES = 1 << PG_SH;
  localparam logic [31:0] ST_RESET = 32'h0080_0000;
  localparam logic [31:0] ST_FAULT = 32'hC082_0000;
  localparam logic [31:0] ST_READ  = 32'h0004_0000;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_CHECK, S_DONE} st_t;
  st_t st;

  logic [31:0]      va_q;
  logic [LEN_W-1:0] rem_q;
  logic             wr_q;
  logic [31:0]      pte_q;
  logic [LEN_W-1:0] pg_left, chunk;
  logic [31:0]      idx;
  logic             bad;

  assign pg_left = LEN_W'(PG_BYTES - {1'b0, va_q[PG_SH-1:0]});
  assign chunk   = (rem_q < pg_left) ? rem_q : pg_left;
  assign idx     = ((va_q & ~cfg_win) >> 10) & ~32'd3;
  assign bad     = !pte_q[1] || (wr_q && !pte_q[2]);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_FETCH);
  assign mem_addr  = {cfg_base, 4'h0} + {4'h0, idx};
  assign out_valid = (st == S_DONE);
  assign out_paddr = {pte_q[31:8], va_q[PG_SH-1:0]};
  assign out_bytes = chunk;
  assign out_last  = (rem_q == chunk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      va_q         <= '0;
      rem_q        <= '0;
      wr_q         <= 1'b0;
      pte_q        <= '0;
      xl_fault     <= 1'b0;
      fault_status <= ST_RESET;
      fault_addr   <= '0;
      irq          <= 1'b0;
    end else begin
      xl_fault <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid && req_len != '0) begin
            va_q  <= req_vaddr;
            rem_q <= req_len;
            wr_q  <= req_write;
            st    <= S_FETCH;
          end
        S_FETCH: st <= S_WAIT;
        S_WAIT:
          if (mem_rvalid) begin
            pte_q <= mem_rdata;
            st    <= S_CHECK;
          end
        S_CHECK:
          if (bad) begin
            fault_status <= ST_FAULT | (wr_q ? 32'h0 : ST_READ);
            fault_addr   <= {va_q[31:PG_SH], {PG_SH{1'b0}}};
            irq          <= 1'b1;
            xl_fault     <= 1'b1;
            st           <= S_IDLE;
          end else begin
            st <= S_DONE;
          end
        S_DONE: begin
          va_q  <= va_q + 32'(chunk);
          rem_q <= rem_q - chunk;
          st    <= (rem_q == chunk) ? S_IDLE : S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_accept_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len != '0) |=> mem_req);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_fault_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (fault_status[31:30] == 2'b11 && fault_status[17] && fault_addr[11:0] == 12'h0));
  p_irq_with_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> irq);
  p_piece_in_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes != '0 && (int'(out_paddr[11:0]) + int'(out_bytes)) <= 4096));
  p_stop_after_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |=> (!mem_req && !out_valid));
  p_excl_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_fault && out_valid));
endmodule

// File: tb/sim_dma_xlate.sv
module sim_dma_xlate;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, irq_clr = 1'b0;
  logic [31:0] req_vaddr = '0, cfg_base = '0, cfg_win = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic mem_req, mem_rvalid = 1'b0;
  logic [35:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic req_ready, out_valid, out_last, xl_fault, irq;
  logic [35:0] out_paddr;
  logic [LEN_W-1:0] out_bytes;
  logic [31:0] fault_status, fault_addr;

  int total = 0, bad = 0;
  int lat = 1, mode = 0;
  logic [31:0] key = 32'h1357_9BDF;
  logic [35:0] stop_ea = '0;
  int rd_n = 0;
  logic [35:0] rd_addr [8];
  bit pend = 0;
  int cnt = 0;
  logic [35:0] pend_addr = '0;

  always #2 clk = ~clk;

  dma_xlate #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_len(req_len), .req_write(req_write),
    .cfg_base(cfg_base), .cfg_win(cfg_win), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_paddr(out_paddr), .out_bytes(out_bytes), .out_last(out_last),
    .xl_fault(xl_fault), .fault_status(fault_status), .fault_addr(fault_addr),
    .irq(irq), .irq_clr(irq_clr));

  function automatic logic [35:0] ea_f(input logic [31:0] va);
    ea_f = {cfg_base, 4'h0} + {4'h0, (((va & ~cfg_win) >> 10) & ~32'd3)};
  endfunction

  function automatic logic [31:0] pte_f(input logic [35:0] ea);
    logic [31:0] h;
    logic v, w;
    h = (ea[31:0] ^ {28'h0, ea[35:32]}) * 32'h9E37_79B1 ^ key;
    h = h ^ (h >> 15);
    case (mode)
      1: begin v = 1'b1; w = 1'b1; end
      2: begin v = 1'b0; w = h[5]; end
      3: begin v = 1'b1; w = 1'b0; end
      4: begin v = (ea != stop_ea); w = 1'b1; end
      default: begin v = (h[3:0] != 4'h0); w = h[5] | h[6]; end
    endcase
    pte_f = {h[31:8], h[7], 4'h0, w, v, h[0]};
  endfunction

  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (cnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pte_f(pend_addr);
        pend <= 0;
      end else cnt <= cnt - 1;
    end
    if (mem_req) begin
      pend <= 1; cnt <= lat; pend_addr <= mem_addr;
      if (rd_n < 8) rd_addr[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] va, input int len, input logic wr, input bit poke);
    logic [35:0] e_ea [8];
    logic [35:0] e_pa [8];
    int e_c [8];
    bit e_last [8];
    int n, nout, got, cyc, r, pl, c;
    bit e_fault, saw_fault, ready_ok;
    logic [31:0] v, fva, p, e_st;
    n = 0; v = va; r = len; e_fault = 0; fva = '0;
    while (r > 0 && n < 8) begin
      e_ea[n] = ea_f(v);
      p = pte_f(e_ea[n]);
      if (!p[1] || (wr && !p[2])) begin
        e_fault = 1; fva = v; n++;
        break;
      end
      pl = 4096 - int'(v[11:0]);
      c = (r < pl) ? r : pl;
      e_pa[n] = {p[31:8], v[11:0]};
      e_c[n] = c;
      e_last[n] = (r == c);
      v = v + c; r = r - c; n++;
    end
    nout = e_fault ? n - 1 : n;
    e_st = wr ? 32'hC082_0000 : 32'hC086_0000;

    @(negedge clk);
    ready_ok = req_ready;
    check(ready_ok, "R1", "ready before request", {63'h0, req_ready}, 64'h1);
    rd_n = 0;
    req_valid = 1'b1; req_vaddr = va; req_len = LEN_W'(len); req_write = wr; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    if (poke) begin
      req_vaddr = va ^ 32'h0055_5000; req_write = ~wr;
    end else req_valid = 1'b0;
    got = 0; saw_fault = 0; cyc = 0;
    forever begin
      if (poke && cyc == 1) req_valid = 1'b0;
      if (out_valid) begin
        if (got < nout) begin
          check(out_paddr == e_pa[got], "R3", "piece address", {28'h0, out_paddr}, {28'h0, e_pa[got]});
          check(int'(out_bytes) == e_c[got] && out_last == e_last[got], "R8", "piece size/last",
                {31'h0, out_last, 16'h0, 16'(out_bytes)}, {31'h0, e_last[got], 16'h0, 16'(e_c[got])});
        end else check(0, "R9", "unexpected piece", 64'(got), 64'(nout));
        got++;
      end
      if (xl_fault) begin
        saw_fault = 1;
        check(e_fault && fault_status == e_st, "R6", "fault status", {32'h0, fault_status}, {32'h0, e_st});
        check(fault_addr == {fva[31:12], 12'h0}, "R6", "fault address", {32'h0, fault_addr}, {32'h0, fva[31:12], 12'h0});
        check(irq == 1'b1, "R7", "irq on fault", {63'h0, irq}, 64'h1);
      end
      if (req_ready && cyc > 0) break;
      cyc++;
      if (cyc > 3000) begin
        check(0, "R1", "request hung", 64'(cyc), 64'h0);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(got == nout, "R8", "piece count", 64'(got), 64'(nout));
    check(saw_fault == e_fault, e_fault ? "R4" : "R3", "fault presence", {63'h0, saw_fault}, {63'h0, e_fault});
    check(rd_n == n, "R9", "table read count", 64'(rd_n), 64'(n));
    for (int i = 0; i < n && i < rd_n && i < 8; i++)
      check(rd_addr[i] == e_ea[i], "R2", "entry address", {28'h0, rd_addr[i]}, {28'h0, e_ea[i]});
  endtask

  initial begin
    #(4 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] va;
    void'($urandom(32'd2024));
    cfg_base = 32'h0123_4C00; cfg_win = 32'hFF00_0000;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && irq == 1'b0 && out_valid == 1'b0 && xl_fault == 1'b0, "R10", "reset outputs",
          {60'h0, req_ready, irq, out_valid, xl_fault}, 64'h8);
    check(fault_status == 32'h0080_0000 && fault_addr == 32'h0, "R10", "reset fault regs",
          {fault_status, fault_addr}, {32'h0080_0000, 32'h0});
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero length request does nothing
    rd_n = 0;
    req_valid = 1'b1; req_len = '0; req_vaddr = 32'hFF00_1000;
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(rd_n == 0 && req_ready && !out_valid, "R1", "zero length no-op", 64'(rd_n), 64'h0);

    // R3 R8: single full page, then a page-crossing write
    mode = 1; lat = 1;
    run_req(32'hFF00_3000, 4096, 1'b0, 0);
    run_req(32'hFF00_3000, 4097, 1'b1, 0);
    lat = 4;
    run_req(32'hFF01_2FF0, 10000, 1'b1, 0);

    // R1: request while busy is ignored
    run_req(32'hFF02_0100, 300, 1'b0, 1);

    // R4: invalid entry, read and write
    mode = 2;
    run_req(32'hFF03_4567, 100, 1'b0, 0);
    run_req(32'hFF03_4567, 100, 1'b1, 0);

    // R5: read-only entry
    mode = 3;
    run_req(32'hFF04_0000, 64, 1'b0, 0);
    run_req(32'hFF04_0000, 64, 1'b1, 0);

    // R7: irq held until cleared
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R7", "irq held", {63'h0, irq}, 64'h1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(irq == 1'b0, "R7", "irq cleared", {63'h0, irq}, 64'h0);

    // R9: fault on third page stops the rest
    mode = 4; lat = 2;
    va = 32'hFF05_0800;
    stop_ea = ea_f(va + 32'h2000);
    run_req(va, 12000, 1'b1, 0);

    // random mix
    mode = 0;
    for (int k = 0; k < 80; k++) begin
      key = $urandom;
      lat = 1 + ($urandom % 5);
      cfg_win = 32'hFFFF_FFFF << (24 + ($urandom % 8));
      cfg_base = $urandom & 32'h07FF_FC00;
      va = cfg_win | ($urandom & ~cfg_win);
      if (k % 3 == 0) va[11:0] = 12'hF00 | 12'($urandom % 256);
      run_req(va, 1 + ($urandom % 9000), 1'($urandom), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule